// File: doc/BRIEF.md
# Timestamped Event Trigger Queue

This block sits between a microinstruction buffer and two fixed-latency execution paths: a pulse-generation path and a measurement-discrimination path. Each queued event carries a destination bit, an 8-bit codeword and a 16-bit relative delay. The codeword is only an index that selects an action already stored downstream, so no waveform data passes through the queue. Because the downstream units have fixed latency, the cycle on which a trigger leaves this block sets the moment the physical operation happens.

Events are accepted over a valid/ready stream and held in a 16-entry in-order queue. A synchronous `start` pulse zeroes a free-running cycle counter and enables dispatch. Each event then fires as a one-cycle strobe with its codeword, on the port its destination selects, exactly `delay` cycles after the previous event fired. A zero delay places two events on the same cycle when they target different ports. The upstream stream follows the usual back-pressure rules. A beat transfers on a rising edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, upstream must keep `in_valid` and its fields stable. `in_ready` depends only on queue occupancy, never on `in_valid`.

If an event reaches the queue after its due cycle has already passed, a sticky underrun flag is raised. That late event is then timed from its own arrival, and the events after it keep their relative spacing.

Top module: `evq_trigger_sched`

## Requirements
- R1: `in_ready` is high exactly when fewer than 16 events are stored. An offered beat is taken only on a cycle with `in_ready` high, and a beat offered while the queue is full is held, not lost.
- R2: Before the first `start`, no trigger fires on either port, and events accepted in that time are kept for later dispatch.
- R3: After a cycle with `start` high, `cycle_count` reads 0 and then rises by one each cycle. A new `start` restarts both the counter and the delay reference.
- R4: With events preloaded before `start`, the first event fires during the cycle in which `cycle_count` equals its delay.
- R5: Each later event with a non-zero delay fires exactly `delay` cycles after the cycle in which the previous event fired, in arrival order.
- R6: Destination 0 fires `pg_fire` and destination 1 fires `md_fire`, each high for one cycle per event with the event's codeword on the matching code port. When a strobe is low, its code port reads 0.
- R7: An event with delay 0 whose destination differs from the event firing before it fires on the same cycle, on the other port.
- R8: An event with delay 0 whose destination port is already in use that cycle fires one cycle later, and this does not set underrun.
- R9: When dispatch is running and an event enters an empty queue after its due cycle has passed, `underrun` is set. That event fires max(delay,1) cycles after the cycle in which it was accepted, and later events are spaced from its firing.
- R10: `underrun` is cleared only by reset, not by `start`. Reset (active-low `rst_n`) empties the queue, stops dispatch and sets `cycle_count` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Zero the counter and begin dispatch |
| in_valid | input | 1 | Upstream event offered |
| in_ready | output | 1 | Queue can take an event |
| in_dest | input | 1 | 0 = pulse path, 1 = measurement path |
| in_code | input | 8 | Codeword index |
| in_delay | input | 16 | Cycles to wait after the previous event fired |
| pg_fire | output | 1 | Pulse-path trigger strobe |
| pg_code | output | 8 | Pulse-path codeword |
| md_fire | output | 1 | Measurement-path trigger strobe |
| md_code | output | 8 | Measurement-path codeword |
| underrun | output | 1 | Sticky late-arrival flag |
| cycle_count | output | 32 | Time base since the last start |

## Verification
The bench targets these cases:
- A zero-delay pair aimed at different ports must land on one cycle. A design that serialised them would put the second trigger one cycle late.
- A zero-delay event following one on the same port must slip by exactly one cycle. A design that got this wrong would either overwrite a strobe or raise a false underrun.
- A late event arriving into an empty queue must raise `underrun` and be re-timed from its arrival. A wrong design would fire it at once, or hold it for a full counter wrap.
- A full queue must hold back a 17th beat until the first event drains, then fire it on its proper cycle. Losing it or taking it early both show up in the pulse-port record.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int unsigned EVQ_DEPTH  = 16;
  localparam int unsigned EVQ_CODE_W = 8;
  localparam int unsigned EVQ_WAIT_W = 16;
  localparam int unsigned EVQ_CNT_W  = 32;

  typedef enum logic {
    DEST_PULSE = 1'b0,
    DEST_MEAS  = 1'b1
  } evq_dest_e;
endpackage

// File: rtl/evq_store.sv
module evq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned EW    = 25,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [EW-1:0] wr_data,
  input  logic [1:0]    pop_n,
  output logic [EW-1:0] head,
  output logic [EW-1:0] second,
  output logic [CW-1:0] fill
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input logic [1:0] n);
    logic [AW:0] s;
    s = {1'b0, p} + (AW+1)'(n);
    if (s >= (AW+1)'(DEPTH)) s = s - (AW+1)'(DEPTH);
    return s[AW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (wr_en) wptr <= adv(wptr, 2'd1);
      rptr <= adv(rptr, pop_n);
      fill <= fill + CW'(wr_en) - CW'(pop_n);
    end
  end

  assign head   = mem[rptr];
  assign second = mem[adv(rptr, 2'd1)];

  // R1: never write into a full store
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (fill < CW'(DEPTH)));
  // R5: never release more entries than are held
  assert_pop_within_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(pop_n) <= fill));
endmodule

// File: rtl/evq_timebase.sv
module evq_timebase #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             running,
  output logic [CNT_W-1:0] tick
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      tick    <= '0;
    end else if (start) begin
      running <= 1'b1;
      tick    <= '0;
    end else if (running) begin
      tick <= tick + 1'b1;
    end
  end

  // R3: start lands the counter on zero and enables dispatch
  assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tick == '0) && running);
  // R3: counter advances by one per cycle while running
  assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |=> (tick == $past(tick) + 1'b1));
endmodule

// File: rtl/evq_dispatch.sv
module evq_dispatch
  import evq_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned WAIT_W = 16,
  localparam int unsigned EW    = 1 + CODE_W + WAIT_W,
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned GW    = WAIT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              running,
  input  logic [EW-1:0]     head,
  input  logic [EW-1:0]     second,
  input  logic [CW-1:0]     fill,
  input  logic              wr_en,
  input  logic [WAIT_W-1:0] wr_delay,
  output logic [1:0]        pop_n,
  output logic              pg_fire,
  output logic [CODE_W-1:0] pg_code,
  output logic              md_fire,
  output logic [CODE_W-1:0] md_code,
  output logic              underrun
);
  localparam logic [GW-1:0] GAP_MAX = '1;

  evq_dest_e         h_dest, s_dest;
  logic [CODE_W-1:0] h_code, s_code;
  logic [WAIT_W-1:0] h_delay, s_delay;
  logic [GW-1:0]     gap, gap_nom;
  logic              head_due, pair_ok, lands_empty, late;

  assign h_dest  = evq_dest_e'(head[EW-1]);
  assign h_code  = head[EW-2 -: CODE_W];
  assign h_delay = head[WAIT_W-1:0];
  assign s_dest  = evq_dest_e'(second[EW-1]);
  assign s_code  = second[EW-2 -: CODE_W];
  assign s_delay = second[WAIT_W-1:0];

  always_comb begin
    head_due = running && (fill != '0) && (gap >= {1'b0, h_delay});
    pair_ok  = head_due && (fill >= CW'(2)) && (s_delay == '0) && (s_dest != h_dest);
    pop_n    = head_due ? (pair_ok ? 2'd2 : 2'd1) : 2'd0;

    pg_fire = 1'b0; pg_code = '0;
    md_fire = 1'b0; md_code = '0;
    if (head_due) begin
      if (h_dest == DEST_PULSE) begin pg_fire = 1'b1; pg_code = h_code; end
      else                      begin md_fire = 1'b1; md_code = h_code; end
    end
    if (pair_ok) begin
      if (s_dest == DEST_PULSE) begin pg_fire = 1'b1; pg_code = s_code; end
      else                      begin md_fire = 1'b1; md_code = s_code; end
    end

    gap_nom     = head_due ? GW'(1) : ((gap == GAP_MAX) ? gap : gap + 1'b1);
    lands_empty = wr_en && (fill == CW'(pop_n));
    late        = running && lands_empty && (gap_nom > {1'b0, wr_delay});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap      <= '0;
      underrun <= 1'b0;
    end else if (start) begin
      gap <= '0;
    end else if (running) begin
      gap <= late ? GW'(1) : gap_nom;
      if (late) underrun <= 1'b1;
    end
  end

  // R2: nothing fires while dispatch is idle
  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!pg_fire && !md_fire));
  // R9, R10: the late flag never drops without reset
  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  // R7: a double release drives both ports on that cycle
  assert_pair_both_ports_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_n == 2'd2) |-> (pg_fire && md_fire));
  // R5: a firing restarts the delay reference
  assert_gap_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pg_fire || md_fire) && !start) |=> (gap == GW'(1)));
endmodule

// File: rtl/evq_trigger_sched.sv
module evq_trigger_sched
  import evq_pkg::*;
#(
  parameter int unsigned DEPTH  = EVQ_DEPTH,
  parameter int unsigned CODE_W = EVQ_CODE_W,
  parameter int unsigned WAIT_W = EVQ_WAIT_W,
  parameter int unsigned CNT_W  = EVQ_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_dest,
  input  logic [CODE_W-1:0] in_code,
  input  logic [WAIT_W-1:0] in_delay,
  output logic              pg_fire,
  output logic [CODE_W-1:0] pg_code,
  output logic              md_fire,
  output logic [CODE_W-1:0] md_code,
  output logic              underrun,
  output logic [CNT_W-1:0]  cycle_count
);
  localparam int unsigned EW = 1 + CODE_W + WAIT_W;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [EW-1:0] head, second;
  logic [CW-1:0] fill;
  logic [1:0]    pop_n;
  logic          wr_en, running;

  assign in_ready = (fill < CW'(DEPTH));
  assign wr_en    = in_valid && in_ready;

  evq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data({in_dest, in_code, in_delay}), .pop_n(pop_n),
    .head(head), .second(second), .fill(fill)
  );

  evq_timebase #(.CNT_W(CNT_W)) u_time (
    .clk(clk), .rst_n(rst_n), .start(start),
    .running(running), .tick(cycle_count)
  );

  evq_dispatch #(.DEPTH(DEPTH), .CODE_W(CODE_W), .WAIT_W(WAIT_W)) u_disp (
    .clk(clk), .rst_n(rst_n), .start(start), .running(running),
    .head(head), .second(second), .fill(fill),
    .wr_en(wr_en), .wr_delay(in_delay), .pop_n(pop_n),
    .pg_fire(pg_fire), .pg_code(pg_code),
    .md_fire(md_fire), .md_code(md_code), .underrun(underrun)
  );

  // R1: stalled upstream beat is not lost while the queue is full
  assert_ready_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(DEPTH)) |-> !in_ready);
endmodule

// File: tb/evq_trigger_sched_test.sv
`timescale 1ns/1ps
module evq_trigger_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_dest = 1'b0;
  logic [7:0]  in_code = '0;
  logic [15:0] in_delay = '0;
  logic        in_ready, pg_fire, md_fire, underrun;
  logic [7:0]  pg_code, md_code;
  logic [31:0] cycle_count;

  always #2.5 clk = ~clk;

  evq_trigger_sched uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_code(in_code), .in_delay(in_delay),
    .pg_fire(pg_fire), .pg_code(pg_code),
    .md_fire(md_fire), .md_code(md_code),
    .underrun(underrun), .cycle_count(cycle_count)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int pg_n = 0, md_n = 0;
  longint pg_t [64], md_t [64];
  int     pg_c [64], md_c [64];

  always @(negedge clk) begin
    if (pg_fire && pg_n < 64) begin pg_t[pg_n] = cycle_count; pg_c[pg_n] = pg_code; pg_n++; end
    if (md_fire && md_n < 64) begin md_t[md_n] = cycle_count; md_c[md_n] = md_code; md_n++; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic d, input logic [7:0] c, input logic [15:0] w);
    in_valid = 1'b1; in_dest = d; in_code = c; in_delay = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // {dest, code, delay}
  localparam logic [24:0] VEC [0:11] = '{
    {1'b0, 8'h11, 16'd3}, {1'b1, 8'h22, 16'd0}, {1'b0, 8'h33, 16'd1},
    {1'b0, 8'h44, 16'd0}, {1'b1, 8'h55, 16'd2}, {1'b1, 8'h66, 16'd5},
    {1'b0, 8'h77, 16'd0}, {1'b0, 8'h88, 16'd1}, {1'b1, 8'h99, 16'd1},
    {1'b0, 8'hAA, 16'd7}, {1'b1, 8'hBB, 16'd0}, {1'b1, 8'hCC, 16'd0}
  };

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    longint t, a;
    bit used_pg, used_md;
    int ip, im;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(in_ready == 1'b1, "R10", "ready after reset", in_ready, 1);
    chk(!pg_fire && !md_fire, "R10", "no strobe after reset", pg_fire | md_fire, 0);
    chk(underrun == 1'b0, "R10", "underrun after reset", underrun, 0);
    chk(cycle_count == 0, "R10", "count after reset", cycle_count, 0);

    // preload the vector table, then idle before start
    for (int i = 0; i < 12; i++) push(VEC[i][24], VEC[i][23:16], VEC[i][15:0]);
    repeat (10) @(negedge clk);
    chk(pg_n == 0 && md_n == 0, "R2", "fires before start", pg_n + md_n, 0);
    chk(cycle_count == 0, "R2", "count idle before start", cycle_count, 0);

    pulse_start();
    chk(cycle_count == 0, "R3", "count right after start", cycle_count, 0);
    repeat (30) @(negedge clk);
    chk(cycle_count == 30, "R3", "count after 30 cycles", cycle_count, 30);
    @(posedge clk);

    // expected firing tick per entry, from the requirements
    t = 0; used_pg = 0; used_md = 0; ip = 0; im = 0;
    for (int i = 0; i < 12; i++) begin
      logic d; logic [7:0] c; logic [15:0] w; bit busy;
      d = VEC[i][24]; c = VEC[i][23:16]; w = VEC[i][15:0];
      busy = d ? used_md : used_pg;
      if (w != 0) begin t = t + w; used_pg = 0; used_md = 0; end        // R4, R5
      else if (busy) begin t = t + 1; used_pg = 0; used_md = 0; end     // R8
      // else: same cycle on the free port, R7
      if (d) used_md = 1; else used_pg = 1;
      if (!d) begin
        chk(pg_t[ip] == t && pg_c[ip] == c, "R6", $sformatf("pulse entry %0d tick", i), pg_t[ip], t);
        ip++;
      end else begin
        chk(md_t[im] == t && md_c[im] == c, "R6", $sformatf("meas entry %0d tick", i), md_t[im], t);
        im++;
      end
    end
    chk(pg_n == ip, "R5", "pulse fire count", pg_n, ip);
    chk(md_n == im, "R7", "meas fire count", md_n, im);
    chk(underrun == 1'b0, "R8", "no underrun from same-port slip", underrun, 0);

    // R9: late arrival into empty queue
    @(negedge clk);
    pg_n = 0; md_n = 0;
    a = cycle_count;
    push(1'b1, 8'hD1, 16'd3);
    push(1'b0, 8'hD2, 16'd2);
    repeat (8) @(negedge clk);
    @(posedge clk);
    chk(underrun == 1'b1, "R9", "underrun set", underrun, 1);
    chk(md_n == 1 && md_t[0] == a + 3 && md_c[0] == 8'hD1, "R9", "late entry tick", md_t[0], a + 3);
    chk(pg_n == 1 && pg_t[0] == a + 5 && pg_c[0] == 8'hD2, "R9", "follower tick", pg_t[0], a + 5);

    // R10: start keeps underrun, reset clears it
    @(negedge clk);
    pulse_start();
    chk(cycle_count == 0, "R3", "restart zeroes count", cycle_count, 0);
    chk(underrun == 1'b1, "R10", "start keeps underrun", underrun, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(underrun == 1'b0, "R10", "reset clears underrun", underrun, 0);
    repeat (3) @(negedge clk);
    chk(cycle_count == 0, "R10", "reset stops count", cycle_count, 0);

    // R1: fill to depth, hold a 17th beat under back-pressure
    pg_n = 0; md_n = 0;
    for (int i = 0; i < 16; i++) push(1'b0, 8'(i + 1), 16'd2);
    chk(in_ready == 1'b0, "R1", "ready low when full", in_ready, 0);
    in_valid = 1'b1; in_dest = 1'b0; in_code = 8'h11; in_delay = 16'd2;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R1", "ready stays low while held", in_ready, 0);
    pulse_start();
    while (!in_ready) @(negedge clk);
    chk(cycle_count == 3, "R1", "ready returns after first drain", cycle_count, 3);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (36) @(negedge clk);
    @(posedge clk);
    chk(pg_n == 17, "R1", "all 17 fired", pg_n, 17);
    chk(pg_t[16] == 34 && pg_c[16] == 8'h11, "R1", "held beat tick", pg_t[16], 34);
    chk(pg_t[0] == 2 && pg_c[0] == 8'h01, "R4", "first tick after start", pg_t[0], 2);
    chk(md_n == 0, "R6", "no meas strobe for pulse events", md_n, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule